// File: doc/BRIEF.md
# Timed Event Sequencer

The sequencer plays back a stored list of event codes at set times after a trigger. A host fills a memory of entries through a write port. Each entry holds a timestamp, an 8-bit event code and a small mask field. Once the block is enabled and armed, a rising edge on the chosen trigger source starts a time counter that runs at the event clock. The entry under the read pointer fires when the counter reaches its timestamp. When it fires, its code appears on the event output for one cycle, unless the mask-enable input suppresses it. The pointer then moves on to the next address.

The reserved code 0x7F ends the list. What happens after it depends on the playback mode. Single mode parks the block until it is disabled and enabled again. Normal mode rearms it for the next trigger. Recycle mode restarts the list from address 0 at once. The last memory address also counts as a terminator, so a list that has no 0x7F cannot run off the end.

The controller has four states. IDLE means disabled. ARMED means enabled and waiting for a trigger. PLAY means the counter is running. DONE means a single-mode run has finished. The transitions are:
- IDLE to ARMED when enabled.
- ARMED to PLAY on a trigger.
- PLAY on the terminator: to DONE in single mode, to ARMED in normal mode, or a restart in PLAY in recycle mode.
- Any state to IDLE when the enable goes low.

Top module: `tseq_top`

## Requirements
- R1: After reset, `busy` and `evt_valid` are low.
- R2: Only a rising edge on `trig_in[trig_sel]` starts playback from ARMED. Edges on the other trigger inputs have no effect.
- R3: The trigger cycle has count 0. An entry with timestamp S that is reached in time has its code on `evt_code` with `evt_valid` high in cycle S+1, so an entry with timestamp 0 at address 0 is seen in the cycle right after the trigger cycle.
- R4: An entry whose mask field has a bit set that is also set in `mask_en` produces no output. It still moves the pointer on and still keeps its place in the timing.
- R5: Code 0x7F ends the list and is never output, whatever its mask.
- R6: Single mode (`mode`=0, and also 3): after the terminator, `busy` drops and triggers are ignored until `enable` goes low and high again.
- R7: Normal mode (`mode`=1): after the terminator, `busy` drops and the next trigger plays the list again from address 0.
- R8: Recycle mode (`mode`=2): the cycle after the terminator's cycle has count 0 again at address 0, so the list repeats with a period equal to the terminator's fire time plus one.
- R9: A trigger that arrives during PLAY is ignored and does not restart the counter.
- R10: At most one entry fires per cycle. An entry whose timestamp is already behind the counter fires in the first cycle after its predecessor, in address order.
- R11: With `enable` low at a clock edge, `evt_valid` and `busy` are low in the following cycle and playback is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Event clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe for the entry memory |
| wr_addr | input | AW | Entry address to write |
| wr_stamp | input | TS_W | Timestamp of the written entry |
| wr_code | input | 8 | Event code of the written entry |
| wr_mask | input | MASK_W | Mask field of the written entry |
| enable | input | 1 | Run enable; low returns the block to IDLE |
| mode | input | 2 | Playback mode: 0 single, 1 normal, 2 recycle, 3 single |
| trig_sel | input | SEL_W | Selects which trigger input is used |
| trig_in | input | NSRC | Trigger sources (counter edge, mains sync, external, software) |
| mask_en | input | MASK_W | Host mask enable; an entry mask bit suppresses only where this is set |
| busy | output | 1 | High while in PLAY |
| evt_valid | output | 1 | Event output strobe |
| evt_code | output | 8 | Event code, zero when no event |

## Verification
The assertions assume that timestamps do not decrease along the list. They also assume the host does not rewrite entries while a list is playing, and that the terminator sits within the written part of memory. The bench keeps to all three: it programs one non-decreasing list while the block is idle or armed, ends it with 0x7F, and only then changes modes, sources and mask enables. Trigger pulses always last one cycle and are driven half a cycle away from the sampling edge. This way each rising edge corresponds to exactly one trigger cycle.

// File: rtl/tseq_pkg.sv
package tseq_pkg;

    localparam int CODE_W = 8;
    localparam logic [CODE_W-1:0] END_CODE = 8'h7F;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_PLAY  = 2'd2,
        ST_DONE  = 2'd3
    } tseq_state_e;

    typedef enum logic [1:0] {
        MODE_SINGLE  = 2'd0,
        MODE_NORMAL  = 2'd1,
        MODE_RECYCLE = 2'd2,
        MODE_RSVD    = 2'd3
    } tseq_mode_e;

endpackage

// File: rtl/tseq_trig.sv
// Trigger source selection with per-source rising-edge detection.
module tseq_trig #(
    parameter int NSRC  = 4,
    parameter int SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  trig_in,
    input  logic [SEL_W-1:0] sel,
    output logic             hit
);
    logic [NSRC-1:0] prev_q;
    logic [NSRC-1:0] rise;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= trig_in;
    end

    assign rise = trig_in & ~prev_q;
    assign hit  = rise[sel];
endmodule

// File: rtl/tseq_store.sv
// Entry memory: host write port, asynchronous read for the playback pointer.
module tseq_store #(
    parameter int DEPTH  = 2048,
    parameter int TS_W   = 32,
    parameter int CODE_W = 8,
    parameter int MASK_W = 4,
    parameter int AW     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [TS_W-1:0]   wr_stamp,
    input  logic [CODE_W-1:0] wr_code,
    input  logic [MASK_W-1:0] wr_mask,
    input  logic [AW-1:0]     rd_addr,
    output logic [TS_W-1:0]   rd_stamp,
    output logic [CODE_W-1:0] rd_code,
    output logic [MASK_W-1:0] rd_mask
);
    localparam int EW = TS_W + CODE_W + MASK_W;

    logic [EW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= {wr_stamp, wr_code, wr_mask};
    end

    assign {rd_stamp, rd_code, rd_mask} = mem[rd_addr];
endmodule

// File: rtl/tseq_fsm.sv
// Playback controller: state register, time counter, read pointer, event output.
module tseq_fsm
    import tseq_pkg::*;
#(
    parameter int DEPTH  = 2048,
    parameter int TS_W   = 32,
    parameter int MASK_W = 4,
    parameter int AW     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [1:0]        mode,
    input  logic              trig_hit,
    input  logic [MASK_W-1:0] mask_en,
    input  logic [TS_W-1:0]   rd_stamp,
    input  logic [CODE_W-1:0] rd_code,
    input  logic [MASK_W-1:0] rd_mask,
    output logic [AW-1:0]     rd_addr,
    output logic              busy,
    output logic              evt_valid,
    output logic [CODE_W-1:0] evt_code
);
    localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

    tseq_state_e       state_q, state_n, end_target;
    tseq_mode_e        mode_e;
    logic [TS_W-1:0]   cnt_q;
    logic [AW-1:0]     addr_q;
    logic              active, fire, last, suppress, emit, restart;

    assign mode_e = tseq_mode_e'(mode);

    always_comb begin
        active   = enable && ((state_q == ST_PLAY) || (state_q == ST_ARMED && trig_hit));
        fire     = active && (rd_stamp <= cnt_q);
        last     = fire && ((rd_code == END_CODE) || (addr_q == LAST_ADDR));
        suppress = |(rd_mask & mask_en);
        emit     = fire && (rd_code != END_CODE) && !suppress;
        restart  = last && (mode_e == MODE_RECYCLE);

        unique case (mode_e)
            MODE_NORMAL:  end_target = ST_ARMED;
            MODE_RECYCLE: end_target = ST_PLAY;
            MODE_SINGLE,
            MODE_RSVD:    end_target = ST_DONE;
            default:      end_target = ST_DONE;
        endcase

        state_n = state_q;
        if (!enable) begin
            state_n = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_n = ST_ARMED;
                ST_ARMED: if (trig_hit) state_n = last ? end_target : ST_PLAY;
                ST_PLAY:  if (last) state_n = end_target;
                ST_DONE:  state_n = ST_DONE;
                default:  state_n = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    // Counter, pointer and event output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            addr_q    <= '0;
            evt_valid <= 1'b0;
            evt_code  <= '0;
        end else begin
            evt_valid <= emit;
            evt_code  <= emit ? rd_code : '0;
            if (state_n == ST_PLAY && !restart) begin
                cnt_q  <= cnt_q + 1'b1;
                addr_q <= addr_q + AW'(fire);
            end else begin
                cnt_q  <= '0;
                addr_q <= '0;
            end
        end
    end

    assign rd_addr = addr_q;
    assign busy    = (state_q == ST_PLAY);
endmodule

// File: rtl/tseq_top.sv
module tseq_top
    import tseq_pkg::*;
#(
    parameter int DEPTH  = 2048,
    parameter int TS_W   = 32,
    parameter int MASK_W = 4,
    parameter int NSRC   = 4,
    localparam int AW    = $clog2(DEPTH),
    localparam int SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [TS_W-1:0]   wr_stamp,
    input  logic [7:0]        wr_code,
    input  logic [MASK_W-1:0] wr_mask,
    input  logic              enable,
    input  logic [1:0]        mode,
    input  logic [SEL_W-1:0]  trig_sel,
    input  logic [NSRC-1:0]   trig_in,
    input  logic [MASK_W-1:0] mask_en,
    output logic              busy,
    output logic              evt_valid,
    output logic [7:0]        evt_code
);
    logic              trig_hit;
    logic [AW-1:0]     rd_addr;
    logic [TS_W-1:0]   rd_stamp;
    logic [CODE_W-1:0] rd_code;
    logic [MASK_W-1:0] rd_mask;

    tseq_trig #(.NSRC(NSRC), .SEL_W(SEL_W)) u_trig (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig_in (trig_in),
        .sel     (trig_sel),
        .hit     (trig_hit)
    );

    tseq_store #(.DEPTH(DEPTH), .TS_W(TS_W), .CODE_W(CODE_W), .MASK_W(MASK_W), .AW(AW)) u_store (
        .clk      (clk),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_stamp (wr_stamp),
        .wr_code  (wr_code),
        .wr_mask  (wr_mask),
        .rd_addr  (rd_addr),
        .rd_stamp (rd_stamp),
        .rd_code  (rd_code),
        .rd_mask  (rd_mask)
    );

    tseq_fsm #(.DEPTH(DEPTH), .TS_W(TS_W), .MASK_W(MASK_W), .AW(AW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .mode      (mode),
        .trig_hit  (trig_hit),
        .mask_en   (mask_en),
        .rd_stamp  (rd_stamp),
        .rd_code   (rd_code),
        .rd_mask   (rd_mask),
        .rd_addr   (rd_addr),
        .busy      (busy),
        .evt_valid (evt_valid),
        .evt_code  (evt_code)
    );
endmodule

// File: rtl/tseq_checker.sv
module tseq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       enable,
    input logic       trig_hit,
    input logic       busy,
    input logic       evt_valid,
    input logic [7:0] evt_code
);
    logic past_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R11: a low enable at an edge silences the next cycle
    assert_quiet_after_disable_R11: assert property (@(posedge clk)
        disable iff (!rst_n || !past_ok)
        !$past(enable) |-> (!evt_valid && !busy));

    // R5: the terminator never reaches the output
    assert_no_terminator_R5: assert property (@(posedge clk)
        disable iff (!rst_n)
        evt_valid |-> (evt_code != 8'h7F));

    // R3: an event needs a running playback or a trigger in the cycle before
    assert_event_has_cause_R3: assert property (@(posedge clk)
        disable iff (!rst_n || !past_ok)
        evt_valid |-> ($past(busy) || $past(trig_hit)));

    // R2: playback begins only on a selected trigger edge
    assert_start_on_trigger_R2: assert property (@(posedge clk)
        disable iff (!rst_n || !past_ok)
        $rose(busy) |-> $past(trig_hit));
endmodule

bind tseq_top tseq_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .trig_hit  (trig_hit),
    .busy      (busy),
    .evt_valid (evt_valid),
    .evt_code  (evt_code)
);

// File: tb/tseq_top_test.sv
module tseq_top_test;
    localparam int DEPTH = 2048;
    localparam int AW    = 11;
    localparam int WMAX  = 64;
    localparam int N     = 8;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        wr_en = 0;
    logic [AW-1:0] wr_addr = '0;
    logic [31:0] wr_stamp = '0;
    logic [7:0]  wr_code = '0;
    logic [3:0]  wr_mask = '0;
    logic        enable = 0;
    logic [1:0]  mode = 2'd1;
    logic [1:0]  trig_sel = 2'd0;
    logic [3:0]  trig_in = '0;
    logic [3:0]  mask_en = '0;
    logic        busy, evt_valid;
    logic [7:0]  evt_code;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    int        st [N] = '{0, 3, 3, 4, 9, 9, 11, 14};
    logic [7:0] cd [N] = '{8'h20, 8'h2A, 8'h24, 8'h25, 8'h2C, 8'h30, 8'h3C, 8'h7F};
    logic [3:0] mk [N] = '{4'h0, 4'h1, 4'h2, 4'h0, 4'h4, 4'h8, 4'h3, 4'hF};

    bit         exp_v [WMAX];
    logic [7:0] exp_c [WMAX];

    tseq_top uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_stamp(wr_stamp), .wr_code(wr_code), .wr_mask(wr_mask),
        .enable(enable), .mode(mode), .trig_sel(trig_sel), .trig_in(trig_in),
        .mask_en(mask_en), .busy(busy), .evt_valid(evt_valid), .evt_code(evt_code)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, expv, $time);
        end
    endtask

    // Expected output per cycle after the trigger, from the timing rules.
    task automatic build(input int md, input logic [3:0] men, input int w);
        int off = 0;
        int lprev = -1;
        int i = 0;
        for (int j = 0; j < WMAX; j++) begin exp_v[j] = 0; exp_c[j] = 8'h00; end
        while (1) begin
            int lt = (st[i] > lprev + 1) ? st[i] : lprev + 1;
            int ab = off + lt;
            if (ab >= w) break;
            if (cd[i] == 8'h7F) begin
                if (md == 2) begin off = ab + 1; lprev = -1; i = 0; continue; end
                break;
            end
            if ((mk[i] & men) == 4'h0) begin exp_v[ab] = 1; exp_c[ab] = cd[i]; end
            lprev = lt;
            i++;
        end
    endtask

    task automatic run_capture(input int w, input int retrig, input int dis_at, input string req);
        @(negedge clk) trig_in[trig_sel] = 1'b1;
        @(posedge clk);
        for (int j = 0; j < w; j++) begin
            @(negedge clk);
            check(evt_valid == exp_v[j] && evt_code == exp_c[j], req,
                  {evt_valid, evt_code}, {exp_v[j], exp_c[j]});
            if (j == 0) trig_in = '0;
            if (j == retrig) trig_in[trig_sel] = 1'b1;
            if (j == retrig + 1) trig_in = '0;
            if (j == dis_at) enable = 1'b0;
        end
    endtask

    task automatic idle_quiet(input int n, input string req);
        for (int j = 0; j < n; j++) begin
            @(negedge clk);
            check(!evt_valid && !busy, req, {busy, evt_valid}, 0);
        end
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        if (!finished) begin
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!busy && !evt_valid, "R1", {busy, evt_valid}, 0);
        rst_n = 1;

        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            wr_en = 1; wr_addr = AW'(i); wr_stamp = st[i]; wr_code = cd[i]; wr_mask = mk[i];
        end
        @(negedge clk) wr_en = 0;
        check(!busy && !evt_valid, "R1", {busy, evt_valid}, 0);

        enable = 1; mode = 2'd1;
        @(negedge clk);

        // R3 R4 R5 R10: mask enable sweep in normal mode
        for (int m = 0; m < 16; m++) begin
            mask_en = 4'(m);
            build(1, mask_en, 20);
            run_capture(20, -1, -1, "R3_R4_R5_R10 mask sweep");
            check(!busy, "R7", busy, 0);
        end
        mask_en = 4'h0;

        // R2: trigger source selection
        for (int s = 0; s < 4; s++) begin
            trig_sel = 2'(s);
            @(negedge clk) trig_in = ~(4'b0001 << s);
            @(negedge clk) trig_in = '0;
            idle_quiet(3, "R2 other sources ignored");
            build(1, 4'h0, 18);
            run_capture(18, -1, -1, "R2 selected source");
        end
        trig_sel = 2'd2;

        // R9: retrigger during playback
        build(1, 4'h0, 20);
        run_capture(20, 6, -1, "R9 retrigger ignored");

        // R7: normal mode waits for the next trigger
        idle_quiet(10, "R7 waiting");
        build(1, 4'h0, 18);
        run_capture(18, -1, -1, "R7 replay");

        // R6: single mode
        mode = 2'd0;
        build(0, 4'h0, 18);
        run_capture(18, -1, -1, "R6 first run");
        for (int j = 0; j < WMAX; j++) begin exp_v[j] = 0; exp_c[j] = 0; end
        run_capture(18, -1, -1, "R6 trigger ignored when done");
        check(!busy, "R6", busy, 0);
        @(negedge clk) enable = 0;
        @(negedge clk) enable = 1;
        @(negedge clk);
        build(0, 4'h0, 18);
        run_capture(18, -1, -1, "R6 rearmed");

        // R8: recycle mode
        mode = 2'd2;
        @(negedge clk) enable = 0;
        @(negedge clk) enable = 1;
        @(negedge clk);
        build(2, 4'h0, 50);
        run_capture(50, -1, -1, "R8 recycle");
        check(busy, "R8", busy, 1);
        @(negedge clk) enable = 0;
        @(negedge clk);
        check(!busy && !evt_valid, "R11", {busy, evt_valid}, 0);

        // R11: abort in the middle of normal playback
        mode = 2'd1;
        enable = 1;
        @(negedge clk);
        build(1, 4'h0, 20);
        for (int j = 5; j < WMAX; j++) begin exp_v[j] = 0; exp_c[j] = 0; end
        run_capture(20, -1, 4, "R11 abort");
        check(!busy, "R11", busy, 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule